// File: doc/BRIEF.md
# Packed-Decimal to Binary Integer Converter

This block turns a packed BCD number into a non-negative 16-bit binary integer. A caller presents the source words, picks the digit count and pulses `start`. The block then takes one decimal digit per clock, most significant digit first. For each digit it multiplies a running total by ten and adds the digit. When the last digit is in, it publishes the integer together with four status flags.

There are two widths. The narrow mode reads four digits from `src_lo`. The wide mode adds a fifth, leading digit taken from the low nibble of `src_hi`. Any digit code from 0xA to 0xF is invalid. Such a digit, or a total beyond the positive 16-bit signed range, raises the overflow flag. An overflow pins the result at 0x7FFF and latches a minor-error flag that stays set until reset.

Top module: `bcd_int_conv`

## Requirements
- R1: With `wide`=0 the result is the decimal value of the four nibbles of `src_lo`, bits 15:12 being the thousands digit and bits 3:0 the units digit; `src_hi` has no effect.
- R2: With `wide`=1, `src_hi[3:0]` is the ten-thousands digit ahead of the four digits of `src_lo`, and `src_hi[15:4]` has no effect.
- R3: If any digit in use holds a code from 0xA to 0xF, `flag_v` is 1 and `result` is 0x7FFF.
- R4: If the decimal value exceeds 32767, `flag_v` is 1 and `result` is 0x7FFF. A value of exactly 32767 or less gives `flag_v`=0 and the exact value.
- R5: `flag_c` and `flag_s` are 0 after every conversion.
- R6: `flag_z` is 1 exactly when the published `result` is zero, so an overflow always gives `flag_z`=0.
- R7: `minor_err` becomes 1 with the first conversion that overflows, stays 1 through later valid conversions, and only reset clears it.
- R8: `done` is a one-cycle pulse that rises on the N+1th rising edge after the edge that samples `start`. N is 4 in narrow mode and 5 in wide mode. `result` and the flags update on that same edge.
- R9: A `start` that arrives while a conversion is in progress is ignored. `result` and the flags hold their values between `done` pulses.
- R10: After reset, `done`, `result`, `minor_err` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion (sampled while idle) |
| wide | input | 1 | 0: four digits, 1: five digits |
| src_lo | input | 16 | Four low BCD digits |
| src_hi | input | 16 | Bits 3:0 hold the leading digit in wide mode |
| done | output | 1 | One-cycle pulse: result and flags updated |
| result | output | 16 | Converted integer, 0x7FFF on overflow |
| flag_c | output | 1 | Carry flag, always 0 |
| flag_v | output | 1 | Overflow: invalid digit or value above 32767 |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Sign flag, always 0 |
| minor_err | output | 1 | Sticky overflow indicator |

## Verification
If the digit counter or the shift register goes wrong, the block takes the wrong number of digits. That shows up in the very next conversion as a wrong `done` latency or as a result scaled by a power of ten. If the invalid-digit tracking is stuck, it shows up in the first conversion that contains a code above 9. The bench therefore mixes valid and invalid digits in every position and also tests the values just around 32767. A lost sticky bit shows up only at the first valid conversion after an overflow, so `minor_err` is compared after every `done`.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } conv_state_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic sign;
    } conv_flags_t;

    function automatic logic nib_is_decimal(input logic [3:0] nib);
        return nib <= 4'd9;
    endfunction

endpackage

// File: rtl/bcd_digit_feed.sv
module bcd_digit_feed #(
    parameter int WORD_W = 16,
    parameter int SR_W   = WORD_W + 4,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic              wide,
    input  logic [WORD_W-1:0] src_lo,
    input  logic [3:0]        src_top,
    output logic [3:0]        cur_nib,
    output logic              last_digit
);
    localparam int LO_DIGITS = WORD_W / 4;
    localparam int HI_DIGITS = LO_DIGITS + 1;

    logic [SR_W-1:0]  digits_q;
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            digits_q <= '0;
            remain_q <= '0;
        end else if (load) begin
            if (wide) begin
                digits_q <= {src_top, src_lo};
                remain_q <= CNT_W'(HI_DIGITS);
            end else begin
                digits_q <= {src_lo, 4'h0};
                remain_q <= CNT_W'(LO_DIGITS);
            end
        end else if (advance) begin
            digits_q <= {digits_q[SR_W-5:0], 4'h0};
            remain_q <= remain_q - 1'b1;
        end
    end

    assign cur_nib    = digits_q[SR_W-1 -: 4];
    assign last_digit = (remain_q == CNT_W'(1));

endmodule

// File: rtl/bcd_mac10.sv
module bcd_mac10 #(
    parameter int ACC_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [3:0]       nib,
    output logic [ACC_W-1:0] acc,
    output logic             bad
);
    import bcd_conv_pkg::*;

    logic [ACC_W-1:0] acc_q;
    logic             bad_q;
    logic [ACC_W-1:0] next_acc;

    always_comb begin
        next_acc = (acc_q << 3) + (acc_q << 1) + {{(ACC_W-4){1'b0}}, nib};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
            bad_q <= 1'b0;
        end else if (step) begin
            acc_q <= next_acc;
            bad_q <= bad_q | ~nib_is_decimal(nib);
        end
    end

    assign acc = acc_q;
    assign bad = bad_q;

endmodule

// File: rtl/bcd_flag_unit.sv
module bcd_flag_unit #(
    parameter int WORD_W = 16,
    parameter int ACC_W  = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [ACC_W-1:0]  acc,
    input  logic              bad,
    output logic [WORD_W-1:0] result,
    output bcd_conv_pkg::conv_flags_t flags,
    output logic              done,
    output logic              minor_err
);
    import bcd_conv_pkg::*;

    localparam logic [WORD_W-1:0] SAT_VAL   = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [ACC_W-1:0]  POS_LIMIT = {{(ACC_W-WORD_W){1'b0}}, SAT_VAL};

    logic              ovf_now;
    logic [WORD_W-1:0] value_now;

    always_comb begin
        ovf_now   = bad || (acc > POS_LIMIT);
        value_now = ovf_now ? SAT_VAL : acc[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            flags     <= '0;
            done      <= 1'b0;
            minor_err <= 1'b0;
        end else begin
            done <= commit;
            if (commit) begin
                result      <= value_now;
                flags.carry <= 1'b0;
                flags.sign  <= 1'b0;
                flags.ovf   <= ovf_now;
                flags.zero  <= (value_now == '0);
                if (ovf_now) minor_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcd_int_conv.sv
module bcd_int_conv #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wide,
    input  logic [WORD_W-1:0] src_lo,
    input  logic [WORD_W-1:0] src_hi,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_s,
    output logic              minor_err
);
    import bcd_conv_pkg::*;

    localparam int MAX_DIGITS = WORD_W / 4 + 1;
    localparam int SR_W       = MAX_DIGITS * 4;
    localparam int CNT_W      = $clog2(MAX_DIGITS + 1);
    localparam int ACC_W      = SR_W + 1;

    conv_state_e      state_q;
    logic             load, advance, commit, last_digit, bad;
    logic [3:0]       cur_nib;
    logic [ACC_W-1:0] acc;
    conv_flags_t      flags;
    logic             unused_hi;

    assign unused_hi = ^src_hi[WORD_W-1:4];

    assign load    = (state_q == ST_IDLE) && start;
    assign advance = (state_q == ST_RUN);
    assign commit  = (state_q == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_q <= ST_RUN;
                ST_RUN:  if (last_digit) state_q <= ST_FIN;
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    bcd_digit_feed #(.WORD_W(WORD_W), .SR_W(SR_W), .CNT_W(CNT_W)) u_feed (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .advance    (advance),
        .wide       (wide),
        .src_lo     (src_lo),
        .src_top    (src_hi[3:0]),
        .cur_nib    (cur_nib),
        .last_digit (last_digit)
    );

    bcd_mac10 #(.ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .step  (advance),
        .nib   (cur_nib),
        .acc   (acc),
        .bad   (bad)
    );

    bcd_flag_unit #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .acc       (acc),
        .bad       (bad),
        .result    (result),
        .flags     (flags),
        .done      (done),
        .minor_err (minor_err)
    );

    assign flag_c = flags.carry;
    assign flag_v = flags.ovf;
    assign flag_z = flags.zero;
    assign flag_s = flags.sign;

endmodule

// File: rtl/bcd_int_conv_chk.sv
module bcd_int_conv_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input logic              flag_c,
    input logic              flag_v,
    input logic              flag_z,
    input logic              flag_s,
    input logic              minor_err
);
    localparam logic [WORD_W-1:0] SAT_VAL = {1'b0, {(WORD_W-1){1'b1}}};

    a_r3_r4_ovf_saturates: assert property (@(posedge clk) disable iff (rst)
        flag_v |-> (result == SAT_VAL));

    a_r4_result_in_range: assert property (@(posedge clk) disable iff (rst)
        !result[WORD_W-1]);

    a_r5_carry_sign_low: assert property (@(posedge clk) disable iff (rst)
        done |-> (!flag_c && !flag_s));

    a_r6_zero_matches: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_z == (result == '0)));

    a_r7_minor_sticky: assert property (@(posedge clk) disable iff (rst)
        minor_err |=> minor_err);

    a_r7_ovf_sets_minor: assert property (@(posedge clk) disable iff (rst)
        (done && flag_v) |-> minor_err);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(flag_v) && $stable(flag_z)));

endmodule

bind bcd_int_conv bcd_int_conv_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .result    (result),
    .flag_c    (flag_c),
    .flag_v    (flag_v),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .minor_err (minor_err)
);

// File: tb/test_bcd_int_conv.sv
module test_bcd_int_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [15:0] src_lo = '0;
    logic [15:0] src_hi = '0;
    logic        done, flag_c, flag_v, flag_z, flag_s, minor_err;
    logic [15:0] result;

    always #4 clk = ~clk;

    bcd_int_conv i_bcd_int_conv (
        .clk(clk), .rst(rst), .start(start), .wide(wide),
        .src_lo(src_lo), .src_hi(src_hi), .done(done), .result(result),
        .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_s(flag_s),
        .minor_err(minor_err)
    );

    typedef struct {
        int    val;
        bit    v;
        bit    z;
        bit    minor;
        int    launch;
        int    ndig;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   exp_minor = 0;
    bit   reported = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
    endtask

    // monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                chk(0, "R9", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(result == 16'(e.val), e.tag, "result", int'(result), e.val);
                chk(flag_v == e.v, e.tag, "flag_v", int'(flag_v), int'(e.v));
                chk(flag_z == e.z, "R6", "flag_z", int'(flag_z), int'(e.z));
                chk(!flag_c && !flag_s, "R5", "carry|sign", int'(flag_c | flag_s), 0);
                chk(minor_err == e.minor, "R7", "minor_err", int'(minor_err), int'(e.minor));
                chk(cyc - e.launch == e.ndig + 2, "R8", "done latency",
                    cyc - e.launch, e.ndig + 2);
            end
        end
    end

    function automatic exp_t model(input bit w, input logic [15:0] lo,
                                   input logic [15:0] hi, input string tag);
        exp_t e;
        int   total = 0;
        bit   bad = 0;
        int   nd = w ? 5 : 4;
        for (int i = nd - 1; i >= 0; i--) begin
            int d;
            d = (i == 4) ? int'(hi[3:0]) : int'((lo >> (4 * i)) & 16'hF);
            if (d > 9) bad = 1;
            total = total * 10 + d;
        end
        e.v     = bad || (total > 32767);
        e.val   = e.v ? 32767 : total;
        e.z     = (e.val == 0);
        e.ndig  = nd;
        e.tag   = tag;
        e.minor = 0;
        e.launch = 0;
        return e;
    endfunction

    task automatic wait_drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic convert(input bit w, input logic [15:0] lo,
                           input logic [15:0] hi, input string tag);
        exp_t e;
        e = model(w, lo, hi, tag);
        @(negedge clk);
        exp_minor = exp_minor | e.v;
        e.minor  = exp_minor;
        e.launch = cyc;
        q.push_back(e);
        start = 1; wide = w; src_lo = lo; src_hi = hi;
        @(negedge clk);
        start = 0;
        wait_drain();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "R8", "watchdog expired", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!done && result == 0 && !flag_c && !flag_v && !flag_z && !flag_s && !minor_err,
            "R10", "reset outputs", int'(result), 0);
        rst = 0;
        @(negedge clk);

        convert(0, 16'h0000, 16'h0000, "R1");
        convert(0, 16'h1234, 16'hFFFF, "R1");
        convert(0, 16'h9999, 16'h0000, "R1");
        convert(0, 16'h0905, 16'h0007, "R1");
        chk(minor_err == 0, "R7", "minor before overflow", int'(minor_err), 0);
        convert(1, 16'h2767, 16'h0003, "R4");
        convert(1, 16'h0000, 16'hABC1, "R2");
        convert(1, 16'h0000, 16'hFFF0, "R2");
        convert(1, 16'h2768, 16'h0003, "R4");
        convert(1, 16'h9999, 16'h0009, "R4");
        convert(0, 16'h12A4, 16'h0000, "R3");
        convert(0, 16'h000F, 16'h0000, "R3");
        convert(1, 16'h0000, 16'h000B, "R3");
        convert(1, 16'h1111, 16'h0001, "R7");
        convert(0, 16'h0001, 16'h0000, "R1");

        // R9: a second start during a conversion is ignored
        begin
            exp_t e;
            e = model(0, 16'h4321, 16'h0000, "R9");
            @(negedge clk);
            e.minor = exp_minor;
            e.launch = cyc;
            q.push_back(e);
            start = 1; wide = 0; src_lo = 16'h4321;
            @(negedge clk);
            start = 0;
            @(negedge clk);
            start = 1; wide = 1; src_lo = 16'h5555; src_hi = 16'h0001;
            @(negedge clk);
            start = 0;
            wait_drain();
            repeat (12) @(negedge clk);
            chk(result == 16'd4321, "R9", "result held", int'(result), 4321);
            chk(!flag_v && !flag_z, "R9", "flags held", int'(flag_v | flag_z), 0);
        end

        // R7/R10: only reset clears the sticky flag
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        chk(minor_err == 0 && result == 0 && !done && !flag_v, "R10",
            "outputs after reset", int'(minor_err), 0);
        rst = 0;
        exp_minor = 0;
        convert(0, 16'h0042, 16'h0000, "R7");

        summary();
        $finish;
    end

endmodule